// File: doc/BRIEF.md
# UART Interrupt and Status Aggregator

This block gathers the event sources of a UART into one place and turns them into readable status bytes and one active-low interrupt line. Receiver, FIFO and special-character logic deliver one-cycle event pulses. The oldest word in the receive FIFO delivers its error flags as levels. The host bus delivers read and write strobes with a register address. A top-level status byte collects the events. Two secondary registers, one for special characters and one for a status group of GPIO and clock events, are sticky and clear when the host reads them. A line status byte reports the error flags of the oldest received word, so its bits stay set until that word is popped, whatever the host reads.

The block also holds the receive stale-data timer. The timer is a three-state machine. In `TMO_IDLE` it is disarmed: the receive FIFO is empty or the programmed limit is zero. In `TMO_COUNT` it counts character-time ticks. In `TMO_EXPIRED` it raises the timeout bit of the line status byte. The transitions are:
- arm (IDLE to COUNT) when the FIFO is non-empty and the limit is non-zero;
- restart (COUNT to COUNT, with the count cleared) on any push or pop;
- expire (COUNT to EXPIRED) on the tick that brings the count to the limit;
- rearm (EXPIRED to COUNT) on any push or pop;
- disarm (any state to IDLE) when the FIFO is empty or the limit is zero.

The interrupt line is low whenever any bit of the top status byte is set and enabled.

Top module: `uart_irq_hub`

## Requirements
- R1: The top status byte reads, bit 7 down to bit 0: CTS change, RX empty, TX empty, TX FIFO trigger, RX FIFO trigger, status group, special character, line error. It resets to 0x60. Each of bits 7..3 is set one cycle after a pulse on its event input.
- R2: A read of address 0 (the top status byte) clears every bit of that byte at the following clock edge.
- R3: The special-character register (6 bits, read at address 2) sets bit k on a pulse of spec_ev[k] and clears when read. Top bit 1 sets one cycle after the AND of this register with the special enable mask first becomes non-zero.
- R4: The group register (8 bits, read at address 3) behaves the same way with grp_ev, the group enable mask and top bit 2.
- R5: The line status byte, read at address 1, is laid out as follows: bit 5 noise, bit 4 break, bit 3 framing, bit 2 parity and bit 1 overrun, taken from head_err[4:0] in that order, and bit 0 the timeout flag. Bits 7..6 read 0. A read does not change it.
- R6: The line enable mask uses the same bit positions as the line status byte. Top bit 0 sets one clock after the AND of the line status byte with this mask first becomes non-zero.
- R7: While the receive FIFO is non-empty and the limit L is non-zero, the timeout flag sets on the L-th char_tick after the last restart.
- R8: A push or a pop clears the timeout flag and restarts the count. An empty FIFO disarms the timer and clears the flag.
- R9: A timeout limit of zero keeps the timeout flag clear.
- R10: irq_n is low exactly when the top status byte ANDed with the top enable mask is non-zero.
- R11: An event that arrives in the same cycle as a clearing read of its register is still set after that read.
- R12: Writes go to address 0 (top enable), address 1 (line enable, 6 bits), address 2 (special enable), address 3 (group enable) and address 4 (timeout limit, which also reads back at address 4). Enables reset to 0 and the limit resets to 0. Reads of addresses 5 to 7 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 3 | Register address for read and write |
| reg_rd | input | 1 | Read strobe; clears the clear-on-read register it addresses |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the addressed register, before any clear |
| ev_cts_chg | input | 1 | CTS change pulse |
| ev_rx_empty | input | 1 | Receive FIFO became empty pulse |
| ev_tx_empty | input | 1 | Transmit FIFO became empty pulse |
| ev_tx_trig | input | 1 | Transmit FIFO trigger level pulse |
| ev_rx_trig | input | 1 | Receive FIFO trigger level pulse |
| spec_ev | input | SPEC_W | Special-character event pulses |
| grp_ev | input | GRP_W | Status group (GPIO, clock) event pulses |
| head_err | input | 5 | Error flags of the oldest received word: noise, break, framing, parity, overrun |
| rx_push | input | 1 | A word entered the receive FIFO |
| rx_pop | input | 1 | A word left the receive FIFO |
| rx_nonempty | input | 1 | Receive FIFO holds at least one word |
| char_tick | input | 1 | One pulse per character time |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The hardest case to reach from the ports is an event and a clearing read that land in the same cycle. The second hardest is a timeout expiry that races a push or a pop. Neither is likely when stimulus is drawn at random with sparse events. The directed phases therefore place a trigger pulse in the very cycle of a top-status read, and walk the timer through arm, partial count, expiry, restart and disarm with hand-placed ticks. A long random phase follows, with dense ticks and frequent small limits, so that restarts land in every timer state. A behavioural model checks the result on every cycle.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
    localparam int BYTE_W = 8;

    localparam logic [2:0] ADDR_TOP  = 3'd0;
    localparam logic [2:0] ADDR_LINE = 3'd1;
    localparam logic [2:0] ADDR_SPEC = 3'd2;
    localparam logic [2:0] ADDR_GRP  = 3'd3;
    localparam logic [2:0] ADDR_TMO  = 3'd4;

    localparam logic [BYTE_W-1:0] TOP_RESET = 8'h60;

    typedef enum logic [1:0] {
        TMO_IDLE    = 2'd0,
        TMO_COUNT   = 2'd1,
        TMO_EXPIRED = 2'd2
    } tmo_state_t;
endpackage

// File: rtl/irq_cor_reg.sv
module irq_cor_reg #(
    parameter int         W   = 8,
    parameter logic [W-1:0] RST = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic [W-1:0] set,
    output logic [W-1:0] q
);
    // A set in the clearing cycle wins over the clear.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= RST;
        else        q <= (clr ? '0 : q) | set;
    end
endmodule

// File: rtl/irq_tmo_fsm.sv
module irq_tmo_fsm
    import uart_irq_pkg::*;
#(
    parameter int TMO_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TMO_W-1:0] limit,
    input  logic             rx_nonempty,
    input  logic             rx_push,
    input  logic             rx_pop,
    input  logic             char_tick,
    output logic             tmo_flag
);
    tmo_state_t       state, state_nx;
    logic [TMO_W-1:0] cnt, cnt_nx;
    logic [TMO_W:0]   cnt_inc;
    logic             disarm, restart;

    assign cnt_inc = {1'b0, cnt} + 1'b1;
    assign disarm  = !rx_nonempty || (limit == '0);
    assign restart = rx_push || rx_pop;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= TMO_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            cnt   <= cnt_nx;
        end
    end

    always_comb begin
        state_nx = state;
        cnt_nx   = cnt;
        if (disarm) begin
            state_nx = TMO_IDLE;
            cnt_nx   = '0;
        end else begin
            unique case (state)
                TMO_IDLE: begin
                    state_nx = TMO_COUNT;
                    cnt_nx   = '0;
                end
                TMO_COUNT: begin
                    if (restart) begin
                        cnt_nx = '0;
                    end else if (char_tick) begin
                        if (cnt_inc >= {1'b0, limit}) state_nx = TMO_EXPIRED;
                        else                          cnt_nx   = cnt_inc[TMO_W-1:0];
                    end
                end
                TMO_EXPIRED: begin
                    if (restart) begin
                        state_nx = TMO_COUNT;
                        cnt_nx   = '0;
                    end
                end
                default: begin
                    state_nx = TMO_IDLE;
                    cnt_nx   = '0;
                end
            endcase
        end
    end

    always_comb begin
        tmo_flag = (state == TMO_EXPIRED);
    end
endmodule

// File: rtl/uart_irq_hub.sv
module uart_irq_hub
    import uart_irq_pkg::*;
#(
    parameter int SPEC_W = 6,
    parameter int GRP_W  = 8,
    parameter int TMO_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        reg_addr,
    input  logic              reg_rd,
    input  logic              reg_wr,
    input  logic [BYTE_W-1:0] reg_wdata,
    output logic [BYTE_W-1:0] reg_rdata,
    input  logic              ev_cts_chg,
    input  logic              ev_rx_empty,
    input  logic              ev_tx_empty,
    input  logic              ev_tx_trig,
    input  logic              ev_rx_trig,
    input  logic [SPEC_W-1:0] spec_ev,
    input  logic [GRP_W-1:0]  grp_ev,
    input  logic [4:0]        head_err,
    input  logic              rx_push,
    input  logic              rx_pop,
    input  logic              rx_nonempty,
    input  logic              char_tick,
    output logic              irq_n
);
    localparam int LINE_W = 6;

    logic [BYTE_W-1:0] top_en;
    logic [LINE_W-1:0] line_en;
    logic [SPEC_W-1:0] spec_en;
    logic [GRP_W-1:0]  grp_en;
    logic [TMO_W-1:0]  tmo_val;

    logic [BYTE_W-1:0] top_q, top_set;
    logic [SPEC_W-1:0] spec_q;
    logic [GRP_W-1:0]  grp_q;
    logic [LINE_W-1:0] line_stat;
    logic              tmo_flag;
    logic              line_agg, spec_agg, grp_agg;
    logic              line_agg_q, spec_agg_q, grp_agg_q;
    logic              rd_top, rd_spec, rd_grp;
    logic [BYTE_W-1:0] spec_byte, grp_byte, tmo_byte;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            top_en  <= '0;
            line_en <= '0;
            spec_en <= '0;
            grp_en  <= '0;
            tmo_val <= '0;
        end else if (reg_wr) begin
            unique case (reg_addr)
                ADDR_TOP:  top_en  <= reg_wdata;
                ADDR_LINE: line_en <= reg_wdata[LINE_W-1:0];
                ADDR_SPEC: spec_en <= reg_wdata[SPEC_W-1:0];
                ADDR_GRP:  grp_en  <= reg_wdata[GRP_W-1:0];
                ADDR_TMO:  tmo_val <= reg_wdata[TMO_W-1:0];
                default: ;
            endcase
        end
    end

    assign rd_top  = reg_rd && (reg_addr == ADDR_TOP);
    assign rd_spec = reg_rd && (reg_addr == ADDR_SPEC);
    assign rd_grp  = reg_rd && (reg_addr == ADDR_GRP);

    irq_tmo_fsm #(.TMO_W(TMO_W)) u_tmo (
        .clk         (clk),
        .rst_n       (rst_n),
        .limit       (tmo_val),
        .rx_nonempty (rx_nonempty),
        .rx_push     (rx_push),
        .rx_pop      (rx_pop),
        .char_tick   (char_tick),
        .tmo_flag    (tmo_flag)
    );

    assign line_stat = {head_err, tmo_flag};
    assign line_agg  = |(line_stat & line_en);
    assign spec_agg  = |(spec_q & spec_en);
    assign grp_agg   = |(grp_q & grp_en);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line_agg_q <= 1'b0;
            spec_agg_q <= 1'b0;
            grp_agg_q  <= 1'b0;
        end else begin
            line_agg_q <= line_agg;
            spec_agg_q <= spec_agg;
            grp_agg_q  <= grp_agg;
        end
    end

    assign top_set = {ev_cts_chg, ev_rx_empty, ev_tx_empty, ev_tx_trig, ev_rx_trig,
                      grp_agg & !grp_agg_q, spec_agg & !spec_agg_q, line_agg & !line_agg_q};

    irq_cor_reg #(.W(BYTE_W), .RST(TOP_RESET)) u_top (
        .clk(clk), .rst_n(rst_n), .clr(rd_top), .set(top_set), .q(top_q)
    );
    irq_cor_reg #(.W(SPEC_W), .RST('0)) u_spec (
        .clk(clk), .rst_n(rst_n), .clr(rd_spec), .set(spec_ev), .q(spec_q)
    );
    irq_cor_reg #(.W(GRP_W), .RST('0)) u_grp (
        .clk(clk), .rst_n(rst_n), .clr(rd_grp), .set(grp_ev), .q(grp_q)
    );

    always_comb begin
        spec_byte = '0;
        spec_byte[SPEC_W-1:0] = spec_q;
        grp_byte = '0;
        grp_byte[GRP_W-1:0] = grp_q;
        tmo_byte = '0;
        tmo_byte[TMO_W-1:0] = tmo_val;
    end

    always_comb begin
        unique case (reg_addr)
            ADDR_TOP:  reg_rdata = top_q;
            ADDR_LINE: reg_rdata = {2'b00, line_stat};
            ADDR_SPEC: reg_rdata = spec_byte;
            ADDR_GRP:  reg_rdata = grp_byte;
            ADDR_TMO:  reg_rdata = tmo_byte;
            default:   reg_rdata = '0;
        endcase
    end

    assign irq_n = !(|(top_q & top_en));
endmodule

// File: rtl/uart_irq_hub_chk.sv
module uart_irq_hub_chk #(
    parameter int SPEC_W = 6,
    parameter int TMO_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [2:0]        reg_addr,
    input logic              reg_rd,
    input logic [SPEC_W-1:0] spec_ev,
    input logic              rx_push,
    input logic              rx_pop,
    input logic              rx_nonempty,
    input logic [7:0]        top_q,
    input logic [7:0]        top_set,
    input logic [SPEC_W-1:0] spec_q,
    input logic [TMO_W-1:0]  tmo_val,
    input logic              tmo_flag,
    input logic              irq_n
);
    logic rd_top_c;
    assign rd_top_c = reg_rd && (reg_addr == 3'd0);

    assert_top_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_top_c && top_set == 8'h00) |=> (top_q == 8'h00));

    assert_irq_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_top_c && top_set == 8'h00) |=> irq_n);

    assert_same_cycle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rd_top_c |=> ((top_q & $past(top_set)) == $past(top_set)));

    assert_spec_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == 3'd2 && spec_ev == '0) |=> (spec_q == '0));

    assert_tmo_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (tmo_val == '0) |=> !tmo_flag);

    assert_tmo_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_nonempty |=> !tmo_flag);

    assert_tmo_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_push || rx_pop) |=> !tmo_flag);
endmodule

bind uart_irq_hub uart_irq_hub_chk #(.SPEC_W(SPEC_W), .TMO_W(TMO_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_addr    (reg_addr),
    .reg_rd      (reg_rd),
    .spec_ev     (spec_ev),
    .rx_push     (rx_push),
    .rx_pop      (rx_pop),
    .rx_nonempty (rx_nonempty),
    .top_q       (top_q),
    .top_set     (top_set),
    .spec_q      (spec_q),
    .tmo_val     (tmo_val),
    .tmo_flag    (tmo_flag),
    .irq_n       (irq_n)
);

// File: tb/uart_irq_hub_bench.sv
module uart_irq_hub_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] reg_addr = '0;
    logic       reg_rd = 1'b0, reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       ev_cts_chg = 0, ev_rx_empty = 0, ev_tx_empty = 0, ev_tx_trig = 0, ev_rx_trig = 0;
    logic [5:0] spec_ev = '0;
    logic [7:0] grp_ev = '0;
    logic [4:0] head_err = '0;
    logic       rx_push = 0, rx_pop = 0, rx_nonempty = 0, char_tick = 0;
    logic       irq_n;

    int n_chk = 0;
    int n_fail = 0;

    // behavioural reference state
    int m_top, m_spec, m_grp, m_top_en, m_line_en, m_spec_en, m_grp_en, m_tmo;
    int m_lprev, m_sprev, m_gprev;
    int m_armed, m_elapsed, m_flag;

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_irq_hub u_uart_irq_hub (.*);

    function automatic int line_byte();
        return (int'(head_err) << 1) | m_flag;
    endfunction

    function automatic int exp_rdata(int a);
        case (a)
            0: return m_top;
            1: return line_byte();
            2: return m_spec;
            3: return m_grp;
            4: return m_tmo;
            default: return 0;
        endcase
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_top = 'h60; m_spec = 0; m_grp = 0;
            m_top_en = 0; m_line_en = 0; m_spec_en = 0; m_grp_en = 0; m_tmo = 0;
            m_lprev = 0; m_sprev = 0; m_gprev = 0;
            m_armed = 0; m_elapsed = 0; m_flag = 0;
        end else begin
            int la, sa, ga, setv;
            la = ((line_byte() & m_line_en) != 0);
            sa = ((m_spec & m_spec_en) != 0);
            ga = ((m_grp & m_grp_en) != 0);
            setv = (ev_cts_chg << 7) | (ev_rx_empty << 6) | (ev_tx_empty << 5) |
                   (ev_tx_trig << 4) | (ev_rx_trig << 3) |
                   ((ga && !m_gprev) << 2) | ((sa && !m_sprev) << 1) | (la && !m_lprev);
            if (reg_rd && reg_addr == 0) m_top = 0;
            m_top = m_top | setv;
            if (reg_rd && reg_addr == 2) m_spec = 0;
            m_spec = m_spec | int'(spec_ev);
            if (reg_rd && reg_addr == 3) m_grp = 0;
            m_grp = m_grp | int'(grp_ev);
            m_lprev = la; m_sprev = sa; m_gprev = ga;
            // stale-data timer
            if (m_tmo == 0 || !rx_nonempty) begin
                m_armed = 0; m_elapsed = 0; m_flag = 0;
            end else if (!m_armed) begin
                m_armed = 1; m_elapsed = 0;
            end else if (rx_push || rx_pop) begin
                m_elapsed = 0; m_flag = 0;
            end else if (char_tick && !m_flag) begin
                m_elapsed++;
                if (m_elapsed >= m_tmo) m_flag = 1;
            end
            if (reg_wr) begin
                case (reg_addr)
                    0: m_top_en  = reg_wdata;
                    1: m_line_en = reg_wdata & 'h3f;
                    2: m_spec_en = reg_wdata & 'h3f;
                    3: m_grp_en  = reg_wdata;
                    4: m_tmo     = reg_wdata;
                    default: ;
                endcase
            end
        end
    end

    task automatic chk(string tag, int act, int expv);
        n_chk++;
        if (act != expv) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, expv);
        end
    endtask

    // advance one clock, then compare against the model away from the edge
    task automatic cyc();
        @(negedge clk);
        case (reg_addr)
            0: chk("R1 top status", reg_rdata, exp_rdata(0));
            1: chk("R5 line status", reg_rdata, exp_rdata(1));
            2: chk("R3 special", reg_rdata, exp_rdata(2));
            3: chk("R4 group", reg_rdata, exp_rdata(3));
            default: chk("R12 readback", reg_rdata, exp_rdata(int'(reg_addr)));
        endcase
        chk("R10 irq_n", irq_n, ((m_top & m_top_en) != 0) ? 0 : 1);
    endtask

    task automatic wr(int a, int d);
        reg_addr = a[2:0]; reg_wdata = d[7:0]; reg_wr = 1; cyc(); reg_wr = 0;
    endtask

    task automatic rd(int a);
        reg_addr = a[2:0]; reg_rd = 1; cyc(); reg_rd = 0;
    endtask

    task automatic peek(int a, string tag, int expv);
        reg_addr = a[2:0]; #1; chk(tag, reg_rdata, expv);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++; n_chk++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        peek(0, "R1 reset value", 'h60);
        chk("R10 reset irq_n", irq_n, 1);

        wr(0, 'hff);
        chk("R10 irq low with enabled bits", irq_n, 0);
        rd(0);
        chk("R2 top cleared by read", reg_rdata, 0);
        chk("R2 irq released", irq_n, 1);

        ev_tx_trig = 1; reg_rd = 1; reg_addr = 0; cyc(); ev_tx_trig = 0; reg_rd = 0;
        chk("R11 event kept over read", reg_rdata, 'h10);
        rd(0);

        wr(2, 'h01);
        spec_ev = 6'h01; cyc(); spec_ev = '0;
        peek(2, "R3 special set", 'h01);
        cyc();
        peek(0, "R3 top bit1", 'h02);
        rd(2); rd(0);
        peek(2, "R3 special cleared", 0);

        wr(3, 'h80);
        grp_ev = 8'h80; cyc(); grp_ev = '0; cyc();
        peek(0, "R4 top bit2", 'h04);
        rd(3); rd(0);

        wr(1, 'h08);
        head_err = 5'b00100; reg_addr = 1; cyc();
        chk("R5 framing at bit3", reg_rdata, 'h08);
        peek(0, "R6 top bit0", 'h01);
        rd(1); rd(1);
        chk("R5 line kept after reads", reg_rdata, 'h08);
        rd(0); cyc();
        peek(0, "R6 no second set while held", 0);
        head_err = '0; cyc();

        wr(4, 3);
        rx_nonempty = 1; rx_push = 1; cyc(); rx_push = 0; cyc();
        reg_addr = 1;
        char_tick = 1; cyc(); char_tick = 0; cyc();
        char_tick = 1; cyc(); char_tick = 0; cyc();
        chk("R7 not yet after two ticks", reg_rdata, 0);
        char_tick = 1; cyc(); char_tick = 0;
        chk("R7 flag after third tick", reg_rdata, 1);
        rx_push = 1; cyc(); rx_push = 0;
        chk("R8 push clears flag", reg_rdata, 0);
        repeat (3) begin char_tick = 1; cyc(); char_tick = 0; cyc(); end
        chk("R7 flag again", reg_rdata, 1);
        rx_nonempty = 0; cyc();
        chk("R8 empty disarms", reg_rdata, 0);
        rx_nonempty = 1; wr(4, 0);
        reg_addr = 1;
        repeat (6) begin char_tick = 1; cyc(); char_tick = 0; end
        chk("R9 zero limit disables", reg_rdata, 0);
        peek(4, "R12 limit readback", 0);
        peek(6, "R12 unused address", 0);

        for (int i = 0; i < 4000; i++) begin
            reg_addr    = 3'($urandom_range(0, 5));
            reg_rd      = ($urandom_range(0, 5) == 0);
            reg_wr      = !reg_rd && ($urandom_range(0, 11) == 0);
            reg_wdata   = (reg_addr == 4) ? 8'($urandom_range(0, 4)) : 8'($urandom);
            ev_cts_chg  = ($urandom_range(0, 15) == 0);
            ev_rx_empty = ($urandom_range(0, 15) == 0);
            ev_tx_empty = ($urandom_range(0, 15) == 0);
            ev_tx_trig  = ($urandom_range(0, 15) == 0);
            ev_rx_trig  = ($urandom_range(0, 15) == 0);
            spec_ev     = ($urandom_range(0, 7) == 0) ? 6'($urandom) : '0;
            grp_ev      = ($urandom_range(0, 7) == 0) ? 8'($urandom) : '0;
            if ($urandom_range(0, 19) == 0) head_err = 5'($urandom);
            if ($urandom_range(0, 29) == 0) rx_nonempty = !rx_nonempty;
            rx_push     = ($urandom_range(0, 9) == 0);
            rx_pop      = ($urandom_range(0, 9) == 0);
            char_tick   = ($urandom_range(0, 1) == 0);
            cyc();
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule